// File: doc/BRIEF.md
# Serial Synthesizer Programming Port

This block is the receiving end of a three-wire serial port that programs a frequency synthesizer. A host drives a serial clock, a data line and a load strobe. On every rising serial-clock edge the block shifts the data line into a 21-bit frame register. On a rising edge of the load strobe, the two low-order control bits of the frame pick one of four holding words, and the 19-bit payload above them is copied into that word.

All three serial inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are found by comparing the synchronized value with its value one cycle earlier. The block presents the four held words in parallel to the divider, phase-detector and mode logic next to it, which is outside this block. On each transfer it also gives a one-cycle pulse with the index of the word that was written.

Top module: `synth_prog_port`

## Requirements
- R1: An asynchronous active-low reset clears the frame register, all four held words and the update pulse and index to zero at once, with no clock edge needed.
- R2: The data line is taken only on a rising serial-clock edge and enters frame bit 0, while the older bits move up one place. Changes on the data line between serial-clock edges have no effect.
- R3: Frame layout: bit 0 is control bit C1, bit 1 is control bit C2, and bits 20..2 are the payload F1..F19, with F19 in bit 20. The frame is sent most significant bit first, so F19 arrives first and C1 arrives last.
- R4: On a rising load-strobe edge the payload is copied into the word picked by index {C2,C1}: 0 reference divider word, 1 main divider word, 2 function word, 3 initialization word.
- R5: A transfer leaves the three words that were not picked unchanged.
- R6: Each transfer raises upd_pulse for exactly one system clock, with upd_sel equal to the index of the word written. A falling load-strobe edge does nothing.
- R7: When more than 21 bits are shifted in before the load strobe, only the last 21 are kept.
- R8: Latency: if the load strobe rises between two system clock edges, the written word and upd_pulse show the change after the third following system clock edge.
- R9: Holding the load strobe high gives a single transfer. The next transfer needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first (asynchronous) |
| ser_le | input | 1 | Load strobe; rising edge transfers the frame (asynchronous) |
| ref_word | output | 19 | Held reference divider word (index 0) |
| main_word | output | 19 | Held main divider word (index 1) |
| func_word | output | 19 | Held function word (index 2) |
| init_word | output | 19 | Held initialization word (index 3) |
| upd_pulse | output | 1 | One-cycle pulse on each transfer |
| upd_sel | output | 2 | Index of the word written, valid with upd_pulse |

## Verification
The bench targets the bit ordering. A design that shifts the wrong way or swaps C1 and C2 writes a bit-reversed payload or sends it to the wrong word. Overlong frames check that the oldest bits are dropped rather than kept. Data toggling while the serial clock is low, and a load strobe held high for many cycles, catch designs that sample on levels instead of edges: such a design corrupts the frame or writes more than once. An exact-cycle latency check and a behavioural model compared on every clock catch a synchronizer stage that is missing or added, and a transfer that uses the frame value from after the shift.

// File: rtl/synth_prog_port.sv
module synth_prog_port #(
  parameter int FRAME_W = 21,
  parameter int CTRL_W  = 2,
  parameter int SYNC_N  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_clk,
  input  logic                      ser_dat,
  input  logic                      ser_le,
  output logic [FRAME_W-CTRL_W-1:0] ref_word,
  output logic [FRAME_W-CTRL_W-1:0] main_word,
  output logic [FRAME_W-CTRL_W-1:0] func_word,
  output logic [FRAME_W-CTRL_W-1:0] init_word,
  output logic                      upd_pulse,
  output logic [CTRL_W-1:0]         upd_sel
);
  localparam int PAY_W  = FRAME_W - CTRL_W;
  localparam int NWORDS = 1 << CTRL_W;

  logic [SYNC_N-1:0]  sck_sy, dat_sy, le_sy;
  logic               sck_q, le_q;
  logic [FRAME_W-1:0] shreg;
  logic [PAY_W-1:0]   hold [NWORDS];

  wire sck_s  = sck_sy[SYNC_N-1];
  wire le_s   = le_sy[SYNC_N-1];
  wire bit_in = dat_sy[SYNC_N-1];
  wire sck_rise = sck_s & ~sck_q;
  wire le_rise  = le_s & ~le_q;
  wire [CTRL_W-1:0] dest = shreg[CTRL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      dat_sy <= '0;
      le_sy  <= '0;
      sck_q  <= 1'b0;
      le_q   <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[SYNC_N-2:0], ser_clk};
      dat_sy <= {dat_sy[SYNC_N-2:0], ser_dat};
      le_sy  <= {le_sy[SYNC_N-2:0], ser_le};
      sck_q  <= sck_s;
      le_q   <= le_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else if (sck_rise) shreg <= {shreg[FRAME_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) hold[i] <= '0;
      upd_pulse <= 1'b0;
      upd_sel   <= '0;
    end else begin
      upd_pulse <= le_rise;
      if (le_rise) begin
        upd_sel <= dest;
        for (int i = 0; i < NWORDS; i++)
          if (dest == i[CTRL_W-1:0]) hold[i] <= shreg[FRAME_W-1:CTRL_W];
      end
    end
  end

  assign ref_word  = hold[0];
  assign main_word = hold[1];
  assign func_word = hold[2];
  assign init_word = hold[3 % NWORDS];

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse);
  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> $past(le_s) && !$past(le_q));
  assert_ref_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_word) |-> upd_pulse && upd_sel == 2'd0);
  assert_main_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(main_word) |-> upd_pulse && upd_sel == 2'd1);
  assert_func_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(func_word) |-> upd_pulse && upd_sel == 2'd2);
  assert_init_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(init_word) |-> upd_pulse && upd_sel == 2'd3);
  assert_frame_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_s && !sck_q) |=> $stable(shreg));
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> ref_word == '0 && main_word == '0 && func_word == '0 && init_word == '0 && !upd_pulse);
endmodule

// File: tb/sim_synth_prog_port.sv
module sim_synth_prog_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [18:0] ref_word, main_word, func_word, init_word;
  logic upd_pulse;
  logic [1:0] upd_sel;
  int checks = 0, errs = 0;

  always #4 clk = ~clk;

  synth_prog_port u0 (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_le(ser_le), .ref_word(ref_word), .main_word(main_word), .func_word(func_word),
    .init_word(init_word), .upd_pulse(upd_pulse), .upd_sel(upd_sel));

  // behavioural reference model
  logic [2:0]  hist [$];
  logic [20:0] m_frame;
  logic [18:0] m_word [4];
  logic        m_pulse;
  logic [1:0]  m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {3'b000, 3'b000, 3'b000};
      m_frame = '0;
      for (int i = 0; i < 4; i++) m_word[i] = '0;
      m_pulse = 1'b0;
      m_sel = '0;
    end else begin
      logic [2:0] now_v, old_v;
      hist.push_back({ser_le, ser_dat, ser_clk});
      while (hist.size() > 4) void'(hist.pop_front());
      now_v = hist[1];
      old_v = hist[0];
      m_pulse = now_v[2] && !old_v[2];
      if (m_pulse) begin
        m_sel = m_frame[1:0];
        m_word[m_frame[1:0]] = m_frame[20:2];
      end
      if (now_v[0] && !old_v[0]) m_frame = {m_frame[19:0], now_v[1]};
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      logic [18:0] got [4];
      got[0] = ref_word; got[1] = main_word; got[2] = func_word; got[3] = init_word;
      for (int i = 0; i < 4; i++) begin
        checks++;
        if (got[i] !== m_word[i]) begin
          errs++;
          $display("FAIL R4 model word %0d: got %h expected %h", i, got[i], m_word[i]);
        end
      end
      checks++;
      if (upd_pulse !== m_pulse || (m_pulse && upd_sel !== m_sel)) begin
        errs++;
        $display("FAIL R6 model pulse/sel: got %b/%0d expected %b/%0d",
                 upd_pulse, upd_sel, m_pulse, m_sel);
      end
    end
  end

  // directed checks
  logic [18:0] exp_w [4];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b; tick(3);
    ser_clk = 1'b1; tick(3);
    ser_clk = 1'b0; tick(3);
  endtask

  task automatic send_frame(input logic [18:0] pay, input logic [1:0] idx);
    logic [20:0] f;
    f = {pay, idx[1], idx[0]};
    for (int i = 20; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic check_all(input string req);
    chk({req, " ref"},  ref_word,  exp_w[0]);
    chk({req, " main"}, main_word, exp_w[1]);
    chk({req, " func"}, func_word, exp_w[2]);
    chk({req, " init"}, init_word, exp_w[3]);
  endtask

  // strobe with exact latency check: pulse seen only at the third negedge
  task automatic strobe(input logic [1:0] idx, input int hold);
    int seen;
    seen = 0;
    ser_le = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (upd_pulse) begin
        seen++;
        chk("R8 pulse cycle", k, 3);
        chk("R6 sel", upd_sel, idx);
      end
    end
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (upd_pulse) seen++;
    end
    ser_le = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (upd_pulse) seen++;
    end
    chk("R9 one pulse per strobe", seen, 1);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_w[i] = '0;
    tick(2);
    check_all("R1 reset");
    chk("R1 reset pulse", upd_pulse, 0);
    rst_n = 1'b1;
    tick(3);

    // R3/R4: each index to its own word
    send_frame(19'h5A5A5, 2'd0); strobe(2'd0, 0); exp_w[0] = 19'h5A5A5; check_all("R4 idx0");
    send_frame(19'h40001, 2'd1); strobe(2'd1, 0); exp_w[1] = 19'h40001; check_all("R3 idx1");
    send_frame(19'h12345, 2'd2); strobe(2'd2, 0); exp_w[2] = 19'h12345; check_all("R5 idx2");
    send_frame(19'h7FFFF, 2'd3); strobe(2'd3, 0); exp_w[3] = 19'h7FFFF; check_all("R4 idx3");

    // R5: rewrite one word, others hold
    send_frame(19'h00000, 2'd1); strobe(2'd1, 0); exp_w[1] = 19'h0; check_all("R5 rewrite");

    // R7: 4 junk bits first, last 21 kept
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    send_frame(19'h2AAAA, 2'd2); strobe(2'd2, 0); exp_w[2] = 19'h2AAAA; check_all("R7 overlong");

    // R2: data toggles with serial clock low do not shift
    send_frame(19'h0F0F0, 2'd0);
    for (int i = 0; i < 8; i++) begin ser_dat = i[0]; tick(2); end
    strobe(2'd0, 0); exp_w[0] = 19'h0F0F0; check_all("R2 data glitch");

    // R9: long hold, single transfer; R6 falling edge no effect
    send_frame(19'h33333, 2'd3); strobe(2'd3, 40); exp_w[3] = 19'h33333; check_all("R9 long hold");

    // R1: async reset mid-run
    #1 rst_n = 1'b0;
    #1;
    for (int i = 0; i < 4; i++) exp_w[i] = '0;
    check_all("R1 async reset");
    chk("R1 async pulse", upd_pulse, 0);
    tick(2);
    rst_n = 1'b1;
    tick(3);
    send_frame(19'h00001, 2'd1); strobe(2'd1, 0); exp_w[1] = 19'h1; check_all("R3 after reset");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule